// File: doc/BRIEF.md
# Binary Keyed Carrier Generator

This block produces a digital test carrier keyed by an on-chip pseudo-random bit stream, meant to feed a DAC for binary phase-shift and amplitude-shift keying experiments. A phase accumulator advances by a fixed tuning word every clock. The top bits of the accumulator address a computed sine lookup that returns offset-binary samples. A bit timer divides the same clock to form the symbol rate, so the data stream is locked to the carrier. At each bit boundary a 7-bit maximal-length LFSR supplies the next data bit and the two-bit mode input is sampled.

At the default setting (125 MHz clock, tuning word 13422, 12500 clocks per bit) the carrier sits near 100 kHz and the data rate is 10 kbit/s. Keying is done by a small state machine whose state is reloaded only at bit boundaries. The states are ST_IDLE (mid-scale output, held from reset until the first boundary), ST_CARRIER (plain carrier), ST_PSK_ZERO (carrier unchanged), ST_PSK_ONE (sine address reduced by half a cycle), ST_ASK_MARK (carrier passed) and ST_ASK_SPACE (mid-scale output). At every boundary the next state is chosen from the mode and the new bit, whatever the current state:
- mode 00 goes to ST_CARRIER.
- mode 01 goes to ST_PSK_ONE on a one and to ST_PSK_ZERO on a zero.
- mode 10 goes to ST_ASK_MARK on a one and to ST_ASK_SPACE on a zero.
- mode 11 goes to ST_IDLE.
Between boundaries the state holds.

Top module: `psk_ask_gen`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, and until the first bit boundary has reached the output, sample_out is the mid-scale code 512 and data_bit is 0.
- R2: The accumulator adds FTW every clock. The sine address is its top ADDR_W bits. sample_out follows the state and the address with a latency of two clocks.
- R3: A bit boundary occurs once every BIT_CYCLES clocks, counted from reset release. data_bit changes only at a boundary.
- R4: The data stream comes from a 7-bit LFSR with polynomial x^7 + x^6 + 1, seeded to all ones. The bit used for an interval is the LFSR MSB before the shift, so the first bit is 1. The sequence repeats every 127 bits and holds 64 ones per period. data_bit presents the current interval's bit.
- R5: Mode 01 (PSK): in a one-bit interval the sine address is the accumulator address minus 2048 (half a cycle, modulo 4096). In a zero-bit interval the address is unchanged.
- R6: Mode 10 (ASK): a one-bit interval outputs the carrier and a zero-bit interval outputs exactly 512.
- R7: Mode 00 outputs the carrier for every bit. Mode 11 outputs exactly 512.
- R8: mode_sel is sampled only at bit boundaries. A change in the middle of an interval has no effect until the next boundary.
- R9: Sine samples are offset binary. Addresses 0..2047 give 512 + m and addresses 2048..4095 give 511 - m, so samples half a cycle apart sum to 1023. The peak is 1023 at address 1024 and the trough is 0 at address 3072. Every sample lies within 4 codes of 511.5 + 511.5*sin(2*pi*addr/4096).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Keying mode: 00 carrier, 01 PSK, 10 ASK, 11 mute |
| sample_out | output | SAMPLE_W | Offset-binary sample for the DAC |
| data_bit | output | 1 | Baseband bit of the current interval |

## Verification
The assertions assume that mode_sel is a clean synchronous input, so its value at a boundary edge is well defined. They also assume that BIT_CYCLES is above one, which keeps boundary pulses isolated. The stimulus changes mode_sel only on falling clock edges, away from the sampling edge. Some changes fall deliberately in mid-interval, so that the hold-until-boundary behaviour is exercised without ever creating an ambiguous sample.

// File: rtl/psk_ask_pkg.sv
package psk_ask_pkg;

    typedef enum logic [1:0] {
        MODE_CARRIER = 2'b00,
        MODE_PSK     = 2'b01,
        MODE_ASK     = 2'b10,
        MODE_MUTE    = 2'b11
    } key_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CARRIER   = 3'd1,
        ST_PSK_ZERO  = 3'd2,
        ST_PSK_ONE   = 3'd3,
        ST_ASK_MARK  = 3'd4,
        ST_ASK_SPACE = 3'd5
    } key_state_e;

endpackage

// File: rtl/carrier_nco.sv
module carrier_nco #(
    parameter int          PHASE_W = 24,
    parameter int          ADDR_W  = 12,
    parameter int unsigned FTW     = 13422
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] phase_addr
);
    localparam logic [PHASE_W-1:0] STEP = PHASE_W'(FTW);

    logic [PHASE_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + STEP;
    end

    assign phase_addr = acc_q[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
    parameter int BIT_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    output logic bit_tick
);
    localparam int CNT_W = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign bit_tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (bit_tick) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen #(
    parameter int LFSR_W = 7,
    parameter int TAP_HI = 7,
    parameter int TAP_LO = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    output logic next_bit,
    output logic held_bit
);
    localparam logic [LFSR_W-1:0] SEED = '1;

    logic [LFSR_W-1:0] lfsr_q;
    logic              feedback;

    assign feedback = lfsr_q[TAP_HI-1] ^ lfsr_q[TAP_LO-1];
    assign next_bit = lfsr_q[LFSR_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q   <= SEED;
            held_bit <= 1'b0;
        end else if (bit_tick) begin
            lfsr_q   <= {lfsr_q[LFSR_W-2:0], feedback};
            held_bit <= next_bit;
        end
    end
endmodule

// File: rtl/key_fsm.sv
module key_fsm
    import psk_ask_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic [1:0] mode_sel,
    input  logic       next_bit,
    output key_state_e state_q,
    output logic       invert,
    output logic       gate
);
    key_state_e state_d;

    // next state: reloaded only at a bit boundary
    always_comb begin
        state_d = state_q;
        if (bit_tick) begin
            unique case (key_mode_e'(mode_sel))
                MODE_CARRIER: state_d = ST_CARRIER;
                MODE_PSK:     state_d = next_bit ? ST_PSK_ONE  : ST_PSK_ZERO;
                MODE_ASK:     state_d = next_bit ? ST_ASK_MARK : ST_ASK_SPACE;
                MODE_MUTE:    state_d = ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the state register only
    always_comb begin
        unique case (state_q)
            ST_IDLE:      begin invert = 1'b0; gate = 1'b0; end
            ST_CARRIER:   begin invert = 1'b0; gate = 1'b1; end
            ST_PSK_ZERO:  begin invert = 1'b0; gate = 1'b1; end
            ST_PSK_ONE:   begin invert = 1'b1; gate = 1'b1; end
            ST_ASK_MARK:  begin invert = 1'b0; gate = 1'b1; end
            ST_ASK_SPACE: begin invert = 1'b0; gate = 1'b0; end
            default:      begin invert = 1'b0; gate = 1'b0; end
        endcase
    end
endmodule

// File: rtl/sine_lut.sv
module sine_lut #(
    parameter int ADDR_W   = 12,
    parameter int SAMPLE_W = 10
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [SAMPLE_W-1:0] sample
);
    localparam int HALF = 1 << (ADDR_W - 1);
    localparam int AMP  = (1 << (SAMPLE_W - 1)) - 1;
    localparam int MID  = 1 << (SAMPLE_W - 1);
    localparam logic [63:0] DEN_BASE = 64'(5) * 64'(HALF) * 64'(HALF);

    logic [63:0]         pos;
    logic [63:0]         prod;
    logic [63:0]         num;
    logic [63:0]         den;
    logic [SAMPLE_W-2:0] mag;

    // rational half-wave approximation: 16q / (5H^2 - 4q), q = p(H - p)
    always_comb begin
        pos  = {{(65 - ADDR_W){1'b0}}, addr[ADDR_W-2:0]};
        prod = pos * (64'(HALF) - pos);
        num  = 64'(AMP) * 64'(16) * prod;
        den  = DEN_BASE - 64'(4) * prod;
        mag  = (SAMPLE_W-1)'(num / den);
        if (addr[ADDR_W-1])
            sample = SAMPLE_W'(MID - 1) - {1'b0, mag};
        else
            sample = SAMPLE_W'(MID) + {1'b0, mag};
    end
endmodule

// File: rtl/psk_ask_gen.sv
module psk_ask_gen
    import psk_ask_pkg::*;
#(
    parameter int          PHASE_W    = 24,
    parameter int          ADDR_W     = 12,
    parameter int          SAMPLE_W   = 10,
    parameter int unsigned FTW        = 13422,
    parameter int          BIT_CYCLES = 12500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_sel,
    output logic [SAMPLE_W-1:0] sample_out,
    output logic                data_bit
);
    localparam logic [ADDR_W-1:0]   HALF_TURN = ADDR_W'(1 << (ADDR_W - 1));
    localparam logic [SAMPLE_W-1:0] MID_CODE  = SAMPLE_W'(1 << (SAMPLE_W - 1));

    logic                bit_tick;
    logic                next_bit;
    logic [ADDR_W-1:0]   carrier_addr;
    key_state_e          key_state;
    logic                invert;
    logic                gate;
    logic [ADDR_W-1:0]   key_addr_q;
    logic                gate_q;
    logic [SAMPLE_W-1:0] lut_sample;

    carrier_nco #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .FTW(FTW)) u_nco (
        .clk(clk), .rst_n(rst_n), .phase_addr(carrier_addr)
    );

    bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick)
    );

    prbs_gen #(.LFSR_W(7), .TAP_HI(7), .TAP_LO(6)) u_prbs (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .next_bit(next_bit), .held_bit(data_bit)
    );

    key_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mode_sel(mode_sel),
        .next_bit(next_bit), .state_q(key_state), .invert(invert), .gate(gate)
    );

    // stage 1: phase keying by address subtraction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_addr_q <= '0;
            gate_q     <= 1'b0;
        end else begin
            key_addr_q <= carrier_addr - (invert ? HALF_TURN : '0);
            gate_q     <= gate;
        end
    end

    sine_lut #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_lut (
        .addr(key_addr_q), .sample(lut_sample)
    );

    // stage 2: amplitude gating to mid-scale
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sample_out <= MID_CODE;
        else        sample_out <= gate_q ? lut_sample : MID_CODE;
    end
endmodule

// File: rtl/psk_ask_gen_chk.sv
module psk_ask_gen_chk #(
    parameter int SAMPLE_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bit_tick,
    input logic                data_bit,
    input logic [2:0]          key_state,
    input logic                gate_q,
    input logic [SAMPLE_W-1:0] sample_out
);
    localparam logic [SAMPLE_W-1:0] MID_CODE = SAMPLE_W'(1 << (SAMPLE_W - 1));

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(data_bit));

    assert_mode_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(key_state));

    // covers ASK space (R6) and mute/idle (R7)
    assert_space_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |=> (sample_out == MID_CODE));
endmodule

bind psk_ask_gen psk_ask_gen_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .data_bit(data_bit),
    .key_state(key_state), .gate_q(gate_q), .sample_out(sample_out)
);

// File: tb/tb_psk_ask_gen.sv
module tb_psk_ask_gen;
    localparam int          PHASE_W = 24;
    localparam int          ADDR_W  = 12;
    localparam int          SAMPLE_W = 10;
    localparam int          B       = 64;
    localparam int unsigned FTW     = 1 << 20;
    localparam int          MID     = 512;
    localparam real         TOL     = 4.0;

    // stimulus rows: {mode[15:14], requirement[13:10], bit count[9:0]}
    localparam logic [15:0] PLAN [0:5] = '{
        {2'd1, 4'd5, 10'd40},
        {2'd2, 4'd6, 10'd40},
        {2'd0, 4'd2, 10'd6},
        {2'd3, 4'd7, 10'd6},
        {2'd1, 4'd8, 10'd24},
        {2'd2, 4'd8, 10'd24}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          mode_sel = 2'd0;
    logic [SAMPLE_W-1:0] sample_out;
    logic                data_bit;

    always #4 clk = ~clk;

    psk_ask_gen #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W),
                  .FTW(FTW), .BIT_CYCLES(B)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .sample_out(sample_out), .data_bit(data_bit)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_tag = "R1";
    bit    chk_en = 1'b0;
    bit    done = 1'b0;

    function automatic string tag_name(int n);
        case (n)
            1: return "R1";  2: return "R2";  3: return "R3";
            4: return "R4";  5: return "R5";  6: return "R6";
            7: return "R7";  8: return "R8";  default: return "R9";
        endcase
    endfunction

    function automatic real sine_ref(int a);
        return 511.5 + 511.5 * $sin(2.0 * 3.141592653589793 * real'(a) / 4096.0);
    endfunction

    task automatic fail(string tag, int act, int exp);
        failures++;
        $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) fail(tag, act, exp);
    endtask

    // reference model: kind 0 mid-scale, 1 carrier, 2 carrier half a turn away
    int                 m_cnt, m_kind, s1_kind, exp_kind, s1_addr, exp_addr, cyc;
    logic [6:0]         m_lfsr;
    logic               m_bit, prev_bit;
    logic [PHASE_W-1:0] m_acc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_kind = 0; s1_kind = 0; exp_kind = 0;
            s1_addr = 0; exp_addr = 0; cyc = 0;
            m_lfsr = 7'h7F; m_bit = 1'b0; m_acc = '0;
        end else begin
            exp_kind = s1_kind;
            exp_addr = s1_addr;
            s1_kind  = m_kind;
            s1_addr  = (int'(m_acc[PHASE_W-1 -: ADDR_W]) + ((m_kind == 2) ? 2048 : 0)) % 4096;
            if (m_cnt == B - 1) begin
                m_bit = m_lfsr[6];
                case (mode_sel)
                    2'd0:    m_kind = 1;
                    2'd1:    m_kind = m_bit ? 2 : 1;
                    2'd2:    m_kind = m_bit ? 1 : 0;
                    default: m_kind = 0;
                endcase
                m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
                m_cnt  = 0;
            end else begin
                m_cnt++;
            end
            m_acc = m_acc + PHASE_W'(FTW);
            cyc++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && chk_en && !done) begin
            checks++;
            if (exp_kind == 0) begin
                if (int'(sample_out) != MID) fail(cur_tag, int'(sample_out), MID);
            end else begin
                real r;
                r = sine_ref(exp_addr);
                if ((real'(sample_out) - r > TOL) || (r - real'(sample_out) > TOL))
                    fail(cur_tag, int'(sample_out), int'(r));
            end
            chk("R4", int'(data_bit), int'(m_bit));
            if (data_bit != prev_bit) chk("R3", cyc % B, 0);
        end
        prev_bit = data_bit;
    end

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    initial begin
        int ones, nonmid, mids, smax, smin;
        int s [0:15];
        // R1: reset state
        repeat (5) @(negedge clk);
        chk("R1", int'(sample_out), MID);
        chk("R1", int'(data_bit), 0);
        rst_n = 1'b1;
        chk_en = 1'b1;
        wait_cyc(B);
        chk("R4", int'(data_bit), 1);           // first bit from all-ones seed
        wait_cyc(B + 1);
        chk("R1", int'(sample_out), MID);       // last idle sample

        // table walk, starting mid-interval so mode changes land off-boundary (R8)
        wait_cyc(B + B / 2);
        foreach (PLAN[i]) begin
            cur_tag  = tag_name(int'(PLAN[i][13:10]));
            mode_sel = PLAN[i][15:14];
            repeat (int'(PLAN[i][9:0]) * B) @(negedge clk);
        end

        // R9: half-turn symmetry and extremes of the carrier
        cur_tag = "R2";
        mode_sel = 2'd0;
        repeat (2 * B) @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            s[k] = int'(sample_out);
            @(negedge clk);
        end
        smax = 0; smin = 1023;
        for (int k = 0; k < 16; k++) begin
            if (s[k] > smax) smax = s[k];
            if (s[k] < smin) smin = s[k];
        end
        for (int k = 0; k < 8; k++) chk("R9", s[k] + s[k + 8], 1023);
        chk("R9", smax, 1023);
        chk("R9", smin, 0);

        // R8: mute requested mid-interval takes effect only at the boundary
        cur_tag = "R8";
        mode_sel = 2'd1;
        repeat (2 * B) @(negedge clk);
        while (cyc % B != B / 2) @(negedge clk);
        mode_sel = 2'd3;
        nonmid = 0;
        for (int k = 0; k < B / 2; k++) begin
            @(negedge clk);
            if (int'(sample_out) != MID) nonmid++;
        end
        chk("R8", (nonmid >= B / 4) ? 1 : 0, 1);
        cur_tag = "R7";
        while (cyc % B != 2) @(negedge clk);
        mids = 0;
        for (int k = 0; k < B - 2; k++) begin
            if (int'(sample_out) == MID) mids++;
            @(negedge clk);
        end
        chk("R7", mids, B - 2);

        // R4: one full sequence period holds 64 ones
        cur_tag = "R5";
        mode_sel = 2'd1;
        ones = 0;
        for (int k = 0; k < 127; k++) begin
            if (data_bit) ones++;
            repeat (B) @(negedge clk);
        end
        chk("R4", ones, 64);

        // R1: reset in mid-run restarts everything
        chk_en = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1", int'(sample_out), MID);
        chk("R1", int'(data_bit), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_en = 1'b1;
        cur_tag = "R6";
        mode_sel = 2'd2;
        wait_cyc(B);
        chk("R4", int'(data_bit), 1);
        repeat (20 * B) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog R3 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule